// File: doc/BRIEF.md
# Chained Descriptor Transmit Queue

This block is one transmit queue that walks a singly linked chain of two-word descriptors held in memory. Software loads the address of the first descriptor into a pointer register and pulses `kick`. The engine reads each descriptor through a one-word-per-beat memory read port. It offers every frame on a valid/ready transmit handshake, then follows the link word to the next descriptor. The walk ends at a descriptor whose link word is zero or whose end-of-list flag is set.

When the walk ends, the pointer register keeps the address of the last descriptor sent. To append work, software writes the head of a new chain into that held descriptor's link word and kicks again. The engine re-reads only the held descriptor's link word, without sending that descriptor a second time, and carries on from the new link. The pointer register can be written only in the initial state. A `stop` pulse returns the queue to that state.

Back-pressure rules: `mem_req` and `mem_addr` stay constant until a cycle with `mem_valid` high, and that cycle consumes one word. `tx_valid`, `tx_addr` and `tx_len` stay constant until a cycle with `tx_ready` high. The only exception is `stop`, which withdraws an offer that has not yet been accepted.

Top module: `ldq_top`

## Requirements
- R1: After reset, `state_o` is 0 (initial), `running` is 0, `ptr_o` is 0, and `mem_req` and `tx_valid` are low.
- R2: A descriptor at address A is read as word 0 (the link) at A and then word 1 at A+4. Word 1 bits 15:0 are the frame length and bit 31 is the end-of-list flag. The frame is then offered with `tx_addr`=A and `tx_len`=length, held stable until `tx_ready`, and never at the same time as `mem_req`.
- R3: After a frame is accepted, the walk ends if that descriptor's link is zero or its end-of-list flag is 1. Otherwise the descriptor at the link address is fetched next.
- R4: `state_o` encodes 0 initial, 1 fetching, 2 transmitting, 3 held at end of list. While held, `ptr_o` equals the address of the last descriptor transmitted.
- R5: A kick while held reads only word 0 of the held descriptor. If that link is non-zero, the walk continues at the link without offering the held descriptor again. If it is zero, the queue returns to held and offers nothing.
- R6: A pointer write while `state_o` is not 0 has no effect on `ptr_o`.
- R7: A kick while fetching or transmitting does not change the sequence of frames offered.
- R8: `stop` lets an outstanding memory beat complete, then brings the queue to the initial state with `running`=0 and `ptr_o`=0. A later pointer write is accepted.
- R9: A kick in the initial state with `ptr_o`=0 is ignored. The two low bits of written pointers and of fetched link words are forced to 0.
- R10: `running` rises on the first accepted start and falls only on `stop` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 32 | Pointer write value |
| kick | input | 1 | Start/resume pulse |
| stop | input | 1 | Return-to-initial command |
| mem_req | output | 1 | Memory read request, held until `mem_valid` |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid, one word per beat |
| mem_data | input | 32 | Read data |
| tx_valid | output | 1 | Frame offer |
| tx_ready | input | 1 | Frame accept |
| tx_addr | output | 32 | Descriptor address of the offered frame |
| tx_len | output | 16 | Frame length |
| state_o | output | 2 | Queue state code |
| running | output | 1 | Queue has been started since the last stop |
| ptr_o | output | 32 | Descriptor pointer register |

## Verification
Assertions check the following on every cycle:
- Memory requests and frame offers stay stable under back-pressure, and the two never overlap.
- A fetch is never started while another is outstanding.
- The pointer stays still while held and ignores writes during a stalled offer.
- `running` is set whenever the queue is out of its initial state.
- A stop with no beat outstanding lands in the initial state on the next cycle.

The bench scenarios cover what the assertions cannot see: the order and content of frames across whole chains, the held address at the end of a chain, resume through a patched link without re-sending, and the null-link resume that sends nothing. They also cover stray kicks in the middle of a walk and the acceptance of a new pointer after a stop.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SEND  = 2'd2,
    ST_HELD  = 2'd3
  } ldq_state_e;
endpackage

// File: rtl/ldq_fetch.sv
// Descriptor reader: one outstanding word at a time, word 0 then word 1.
module ldq_fetch #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 16,
  parameter int VEOL_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic          start_link_only,
  input  logic          abort,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          beat,
  output logic          done,
  output logic [AW-1:0] link,
  output logic          veol,
  output logic [LEN_W-1:0] len
);
  localparam int WB         = DW / 8;
  localparam int ALIGN_BITS = $clog2(WB);

  logic          busy_q, widx_q, link_only_q, done_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] w0_q, w1_q;

  assign mem_req  = busy_q;
  assign mem_addr = base_q + (widx_q ? AW'(WB) : AW'(0));
  assign beat     = busy_q & mem_valid;
  assign done     = done_q;
  assign link     = {w0_q[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  assign veol     = w1_q[VEOL_BIT];
  assign len      = w1_q[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      widx_q      <= 1'b0;
      link_only_q <= 1'b0;
      done_q      <= 1'b0;
      base_q      <= '0;
      w0_q        <= '0;
      w1_q        <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q      <= 1'b1;
        widx_q      <= 1'b0;
        base_q      <= start_base;
        link_only_q <= start_link_only;
      end else if (beat) begin
        if (abort) begin
          busy_q <= 1'b0;
        end else if (!widx_q) begin
          w0_q <= mem_data;
          if (link_only_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            widx_q <= 1'b1;
          end
        end else begin
          w1_q   <= mem_data;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/ldq_ctrl.sv
// Queue sequencer: pointer register, state, end-of-list and resume decisions.
module ldq_ctrl
  import ldq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          kick,
  input  logic          stop,
  input  logic          f_req,
  input  logic          f_beat,
  input  logic          f_done,
  input  logic [AW-1:0] f_link,
  input  logic          f_veol,
  input  logic [LEN_W-1:0] f_len,
  output logic          f_start,
  output logic [AW-1:0] f_base,
  output logic          f_link_only,
  output logic          f_abort,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [AW-1:0] tx_addr,
  output logic [LEN_W-1:0] tx_len,
  output ldq_state_e    state,
  output logic          running,
  output logic [AW-1:0] ptr
);
  localparam int ALIGN_BITS = 2;

  ldq_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic          running_q, resume_q, stop_pend_q;
  logic          end_hit, stop_any, stop_now;

  assign end_hit  = (f_link == '0) || f_veol;
  assign stop_any = stop || stop_pend_q;
  assign stop_now = stop_any && (state_q != ST_FETCH || f_beat || !f_req);
  assign f_abort  = stop_any;

  assign tx_valid = (state_q == ST_SEND);
  assign tx_addr  = ptr_q;
  assign tx_len   = f_len;
  assign state    = state_q;
  assign running  = running_q;
  assign ptr      = ptr_q;

  always_comb begin
    f_start     = 1'b0;
    f_base      = ptr_q;
    f_link_only = 1'b0;
    if (!stop_any) begin
      unique case (state_q)
        ST_IDLE:  f_start = kick && (ptr_q != '0);
        ST_HELD:  begin f_start = kick; f_link_only = 1'b1; end
        ST_FETCH: begin
          f_start = f_done && resume_q && (f_link != '0);
          f_base  = f_link;
        end
        ST_SEND:  begin
          f_start = tx_ready && !end_hit;
          f_base  = f_link;
        end
        default:  f_start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      running_q   <= 1'b0;
      resume_q    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (stop_now) begin
      state_q     <= ST_IDLE;
      ptr_q       <= '0;
      running_q   <= 1'b0;
      resume_q    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (stop) begin
      stop_pend_q <= 1'b1;
    end else if (!stop_pend_q) begin
      unique case (state_q)
        ST_IDLE: begin
          if (ptr_wr) ptr_q <= {ptr_wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
          if (f_start) begin
            state_q   <= ST_FETCH;
            running_q <= 1'b1;
            resume_q  <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (f_done) begin
            if (resume_q) begin
              resume_q <= 1'b0;
              if (f_link != '0) ptr_q <= f_link;
              else state_q <= ST_HELD;
            end else begin
              state_q <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (tx_ready) begin
            if (end_hit) state_q <= ST_HELD;
            else begin
              ptr_q   <= f_link;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_HELD: begin
          if (kick) begin
            state_q  <= ST_FETCH;
            resume_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !stop) |=> (tx_valid && $stable(tx_addr) && $stable(tx_len)));

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && f_req));

  assert_held_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && !kick && !stop) |=> (state_q == ST_HELD && $stable(ptr_q)));

  assert_ptr_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && state_q == ST_SEND && !tx_ready && !stop) |=> $stable(ptr_q));

  assert_zero_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && kick && ptr_q == '0 && !ptr_wr) |=> (state_q == ST_IDLE));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !f_req) |=> (state_q == ST_IDLE && !running_q));

  assert_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> running_q);
endmodule

// File: rtl/ldq_top.sv
module ldq_top
  import ldq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LEN_W    = 16,
  parameter int VEOL_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             kick,
  input  logic             stop,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_valid,
  input  logic [DW-1:0]    mem_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [AW-1:0]    tx_addr,
  output logic [LEN_W-1:0] tx_len,
  output logic [1:0]       state_o,
  output logic             running,
  output logic [AW-1:0]    ptr_o
);
  logic             f_start, f_link_only, f_abort, f_beat, f_done, f_veol;
  logic [AW-1:0]    f_base, f_link;
  logic [LEN_W-1:0] f_len;
  ldq_state_e       st;

  assign state_o = st;

  ldq_fetch #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .VEOL_BIT(VEOL_BIT)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(f_start), .start_base(f_base), .start_link_only(f_link_only), .abort(f_abort),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .beat(f_beat), .done(f_done), .link(f_link), .veol(f_veol), .len(f_len)
  );

  ldq_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .kick(kick), .stop(stop),
    .f_req(mem_req), .f_beat(f_beat), .f_done(f_done),
    .f_link(f_link), .f_veol(f_veol), .f_len(f_len),
    .f_start(f_start), .f_base(f_base), .f_link_only(f_link_only), .f_abort(f_abort),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_len(tx_len),
    .state(st), .running(running), .ptr(ptr_o)
  );
endmodule

// File: tb/sim_ldq_top.sv
module sim_ldq_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ptr_wr = 1'b0, kick = 1'b0, stop = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        mem_req, mem_valid = 1'b0, tx_valid, tx_ready = 1'b0, running;
  logic [31:0] mem_addr, mem_data = '0, tx_addr, ptr_o;
  logic [15:0] tx_len;
  logic [1:0]  state_o;

  always #5 clk = ~clk;

  ldq_top u0 (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .kick(kick), .stop(stop),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_addr(tx_addr), .tx_len(tx_len),
    .state_o(state_o), .running(running), .ptr_o(ptr_o)
  );

  logic [31:0] mem [0:255];
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;
  logic [31:0] got_a [0:63];
  logic [15:0] got_l [0:63];
  int          got_n = 0;
  logic [31:0] exp_a [0:31];
  logic [15:0] exp_l [0:31];
  int          exp_n = 0;
  logic [31:0] nxt = 32'h10;
  bit          resp_en = 1'b1;

  // Memory and sink responder; records every accepted frame.
  initial begin
    forever begin
      @(negedge clk);
      mem_valid = resp_en && mem_req && ($urandom % 2 == 0);
      mem_data  = mem[mem_addr[9:2]];
      tx_ready  = resp_en && ($urandom % 3 != 0);
      if (tx_valid && tx_ready && got_n < 64) begin
        got_a[got_n] = tx_addr;
        got_l[got_n] = tx_len;
        got_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v; @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic wait_held(input bit spray);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (state_o == 2'd3 && !mem_req) return;
      if (spray && (state_o == 2'd1 || state_o == 2'd2) && ($urandom % 4 == 0)) begin
        kick = 1'b1; @(negedge clk); kick = 1'b0;
      end
    end
    chk(1'b0, "R3", "walk never ended", {30'd0, state_o}, 32'd3);
  endtask

  // Expected frames when walking from head.
  task automatic build_exp(input logic [31:0] head);
    logic [31:0] a, lnk, w1;
    exp_n = 0;
    a = head;
    while (a != 0 && exp_n < 32) begin
      lnk = mem[a[9:2]] & 32'hFFFF_FFFC;
      w1  = mem[a[9:2] + 8'd1];
      exp_a[exp_n] = a;
      exp_l[exp_n] = w1[15:0];
      exp_n++;
      if (lnk == 0 || w1[31]) break;
      a = lnk;
    end
  endtask

  task automatic compare(input string req);
    chk(got_n == exp_n, req, "frame count", got_n, exp_n);
    if (got_n == exp_n)
      for (int i = 0; i < exp_n; i++) begin
        chk(got_a[i] == exp_a[i], req, "frame addr", got_a[i], exp_a[i]);
        chk(got_l[i] == exp_l[i], req, "frame len", {16'd0, got_l[i]}, {16'd0, exp_l[i]});
      end
  endtask

  // Chain of n descriptors; ends by end-of-list flag (junk link) or null link.
  task automatic make_chain(input int n, input bit by_flag, output logic [31:0] head);
    logic [31:0] a, w1;
    head = nxt;
    for (int i = 0; i < n; i++) begin
      a  = nxt;
      nxt = nxt + 32'd8;
      w1 = {1'b0, 15'($urandom), 16'($urandom)};
      if (i == n - 1) begin
        mem[a[9:2]] = by_flag ? 32'h0000_03F8 : 32'h0;
        w1[31] = by_flag;
      end else begin
        mem[a[9:2]] = nxt | (($urandom % 2 == 0) ? 32'h1 : 32'h0);
      end
      mem[a[9:2] + 8'd1] = w1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] h1, h2, last;
    void'($urandom(32'd2468));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state_o == 2'd0, "R1", "state", {30'd0, state_o}, 0);
    chk(!running && !mem_req && !tx_valid, "R1", "flags", {mem_req, tx_valid, running}, 0);
    chk(ptr_o == 0, "R1", "ptr", ptr_o, 0);

    // R9: kick with zero pointer ignored
    pulse_kick();
    repeat (3) @(negedge clk);
    chk(state_o == 2'd0 && !mem_req && !running, "R9", "zero-ptr kick", {30'd0, state_o}, 0);

    // R9: low bits masked
    write_ptr(32'h0000_0043);
    chk(ptr_o == 32'h40, "R9", "aligned ptr", ptr_o, 32'h40);
    pulse_stop();

    // R2/R3/R4/R10: three descriptors, null end
    make_chain(3, 1'b0, h1);
    write_ptr(h1);
    got_n = 0;
    pulse_kick();
    chk(running, "R10", "running after start", {31'd0, running}, 1);
    wait_held(1'b0);
    build_exp(h1);
    compare("R2");
    last = exp_a[exp_n-1];
    chk(ptr_o == last, "R4", "held ptr", ptr_o, last);
    chk(state_o == 2'd3 && running, "R10", "held and running", {30'd0, state_o}, 3);

    // R6: writes ignored while held
    write_ptr(32'h0000_0200);
    chk(ptr_o == last, "R6", "ptr after locked write", ptr_o, last);

    // R5: resume with link still null sends nothing
    got_n = 0;
    pulse_kick();
    wait_held(1'b0);
    chk(got_n == 0, "R5", "null resume frames", got_n, 0);
    chk(ptr_o == last, "R5", "null resume ptr", ptr_o, last);

    // R5/R3: patch link to a chain ending on the flag, with kicks sprayed (R7)
    make_chain(4, 1'b1, h2);
    mem[last[9:2]] = h2;
    got_n = 0;
    pulse_kick();
    wait_held(1'b1);
    build_exp(h2);
    compare("R5");
    chk(ptr_o == exp_a[exp_n-1], "R7", "ptr after sprayed kicks", ptr_o, exp_a[exp_n-1]);

    // R8: stop during an outstanding fetch
    pulse_stop();
    nxt = 32'h10;
    make_chain(3, 1'b0, h1);
    write_ptr(h1);
    pulse_kick();
    for (int i = 0; i < 20 && !mem_req; i++) @(negedge clk);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    repeat (12) @(negedge clk);
    chk(state_o == 2'd0 && !running, "R8", "stopped state", {29'd0, running, state_o}, 0);
    chk(ptr_o == 0 && !mem_req && !tx_valid, "R8", "stopped ptr", ptr_o, 0);
    write_ptr(32'h0000_0060);
    chk(ptr_o == 32'h60, "R8", "write after stop", ptr_o, 32'h60);
    pulse_stop();

    // Random rounds: chain, held, patch, resume
    for (int r = 0; r < 25; r++) begin
      nxt = 32'h10;
      make_chain(1 + int'($urandom % 5), 1'($urandom), h1);
      write_ptr(h1);
      got_n = 0;
      pulse_kick();
      wait_held(1'($urandom));
      build_exp(h1);
      compare("R3");
      last = exp_a[exp_n-1];
      chk(ptr_o == last, "R4", "random held ptr", ptr_o, last);
      make_chain(1 + int'($urandom % 5), 1'($urandom), h2);
      mem[last[9:2]] = h2;
      got_n = 0;
      pulse_kick();
      wait_held(1'b0);
      build_exp(h2);
      compare("R5");
      pulse_stop();
      repeat (2) @(negedge clk);
      chk(state_o == 2'd0 && ptr_o == 0, "R8", "round stop", ptr_o, 0);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule